// File: doc/BRIEF.md
# Root Hub Status and Power Command Register

This block is the 32-bit status and control word of a USB host controller's root hub. It sits at a fixed offset on a simple register bus. Software uses write-one commands in it to switch downstream port power on or off. It also arms and disarms a remote wake-up enable and reads back a global overcurrent level together with a sticky change flag.

Several bit positions have one meaning on read and another on write. The power commands can be applied to every port at once. In per-port switching mode they are filtered through a per-port mask, so a masked port keeps its power state.

Two further functions use the register's state:
- The overcurrent input is synchronized, and each change of the synchronized level is recorded.
- While the wake enable is armed and the controller is suspended, a connect-status change on any port raises a one-cycle resume pulse.

Top module: `rh_status_ctl`

## Requirements
- R1: The register answers only at address offset 0x50. Reads at any other address return 0, and writes there change nothing. Reserved bits 30..18 and 14..2 always read 0, and writing ones to them has no effect on any state or output.
- R2: After a synchronous reset, every implemented bit reads 0, all `port_power` outputs are 0 and `resume_pulse` is 0.
- R3: Bit 15 reads the wake enable. Writing 1 to bit 15 arms it, and writing 0 there leaves it unchanged.
- R4: Writing 1 to bit 31 disarms the wake enable, and bit 31 always reads 0. If one write carries ones in both bit 15 and bit 31, the enable ends up disarmed.
- R5: Writing 1 to bit 16 is a power-on command, and bit 16 always reads 0. With `per_port_mode` = 0 the command powers every port one cycle after the write.
- R6: With `per_port_mode` = 1, the power-on and power-off commands act only on ports whose `port_power_mask` bit is 0. Ports whose mask bit is 1 keep their power state.
- R7: Writing 1 to bit 0 is a power-off command on the same targets, and bit 0 always reads 0. If one write carries ones in both bit 16 and bit 0, the targeted ports end up unpowered.
- R8: Bit 1 reads the overcurrent input level delayed by two clock edges. It reads 0 whenever `per_port_ovc` = 1.
- R9: With `per_port_ovc` = 0, bit 17 is set on the third edge after `ovc_in` changes and then holds. Writing 1 to bit 17 clears it. If a hardware set and a software clear fall on the same edge, the flag stays set.
- R10: `resume_pulse` is 1 for the cycle after an edge at which all three conditions hold: the wake enable is armed, `suspended` is 1, and any `port_csc` bit is 1. It stays 0 when the enable is disarmed or `suspended` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| per_port_mode | input | 1 | 0 = global power switching, 1 = per-port switching |
| per_port_ovc | input | 1 | 1 = per-port overcurrent protection selected |
| port_power_mask | input | N_PORTS | 1 = port ignores the power commands in per-port mode |
| port_power | output | N_PORTS | Power state of each port |
| ovc_in | input | 1 | Asynchronous global overcurrent level |
| port_csc | input | N_PORTS | Connect-status-change events per port |
| suspended | input | 1 | Controller is in the suspend state |
| resume_pulse | output | 1 | One-cycle resume-detected pulse |

## Verification
Each result is due at a known number of edges after its stimulus:
- Register writes, port power and the resume pulse appear one edge after the write or event.
- The overcurrent level appears two edges after `ovc_in` moves, and the change flag appears three edges after.

The bench drives every stimulus on the falling edge and counts rising edges explicitly before it samples. For the overcurrent case it samples one edge early to show the flag is not yet set. It times the clear write of the change flag to land exactly on the third edge, which exercises the case where the set and the clear collide.

// File: rtl/rh_status_pkg.sv
package rh_status_pkg;

    localparam int REG_W = 32;

    localparam int B_PWR_CLR  = 0;
    localparam int B_OVC_LVL  = 1;
    localparam int B_WAKE     = 15;
    localparam int B_PWR_SET  = 16;
    localparam int B_OVC_CHG  = 17;
    localparam int B_WAKE_CLR = 31;

    typedef struct packed {
        logic wake_set;
        logic wake_clr;
        logic pwr_set;
        logic pwr_clr;
        logic chg_clr;
    } rh_cmd_t;

    typedef struct packed {
        logic wake_en;
        logic ovc_lvl;
        logic ovc_chg;
    } rh_view_t;

    function automatic rh_cmd_t decode_cmd(input logic strobe, input logic [REG_W-1:0] d);
        rh_cmd_t c;
        c.wake_set = strobe & d[B_WAKE];
        c.wake_clr = strobe & d[B_WAKE_CLR];
        c.pwr_set  = strobe & d[B_PWR_SET];
        c.pwr_clr  = strobe & d[B_PWR_CLR];
        c.chg_clr  = strobe & d[B_OVC_CHG];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_view(input rh_view_t v);
        logic [REG_W-1:0] r;
        r = '0;
        r[B_WAKE]    = v.wake_en;
        r[B_OVC_LVL] = v.ovc_lvl;
        r[B_OVC_CHG] = v.ovc_chg;
        return r;
    endfunction

endpackage

// File: rtl/rh_power_switch.sv
module rh_power_switch #(
    parameter int N_PORTS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_set,
    input  logic               cmd_clr,
    input  logic               per_port_mode,
    input  logic [N_PORTS-1:0] mask,
    output logic [N_PORTS-1:0] power
);
    logic [N_PORTS-1:0] target;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign target[p] = per_port_mode ? ~mask[p] : 1'b1;

        always_ff @(posedge clk) begin
            if (rst)
                power[p] <= 1'b0;
            else if (target[p] && cmd_clr)
                power[p] <= 1'b0;
            else if (target[p] && cmd_set)
                power[p] <= 1'b1;
        end

        // R6: masked ports hold their state under any command
        a_r6_mask_holds: assert property (@(posedge clk) disable iff (rst)
            ((cmd_set || cmd_clr) && per_port_mode && mask[p]) |=> $stable(power[p]));
    end

    // R7: a combined set and clear leaves the targeted ports off
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (cmd_set && cmd_clr) |=> ((power & $past(target)) == '0));

    // R5: a lone set in global mode powers every port
    a_r5_global_on: assert property (@(posedge clk) disable iff (rst)
        (cmd_set && !cmd_clr && !per_port_mode) |=> (&power));

endmodule

// File: rtl/rh_ovc_track.sv
module rh_ovc_track (
    input  logic clk,
    input  logic rst,
    input  logic ovc_async,
    input  logic per_port_ovc,
    input  logic chg_clr,
    output logic lvl,
    output logic chg
);
    logic s1, s2, s3;
    logic edge_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b0;
            s2 <= 1'b0;
            s3 <= 1'b0;
        end else begin
            s1 <= ovc_async;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign edge_seen = (s2 != s3) && !per_port_ovc;

    always_ff @(posedge clk) begin
        if (rst)
            chg <= 1'b0;
        else if (edge_seen)
            chg <= 1'b1;
        else if (chg_clr)
            chg <= 1'b0;
    end

    assign lvl = per_port_ovc ? 1'b0 : s2;

    // R9: a detected change sets the flag even against a clear
    a_r9_set_wins: assert property (@(posedge clk) disable iff (rst)
        edge_seen |=> chg);

    // R9: without a change, a clear empties the flag
    a_r9_clear: assert property (@(posedge clk) disable iff (rst)
        (chg_clr && !edge_seen) |=> !chg);

endmodule

// File: rtl/rh_wake_ctl.sv
module rh_wake_ctl #(
    parameter int N_PORTS = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               set_en,
    input  logic               clr_en,
    input  logic               suspended,
    input  logic [N_PORTS-1:0] csc,
    output logic               wake_en,
    output logic               resume_pulse
);
    logic trig;

    always_ff @(posedge clk) begin
        if (rst)
            wake_en <= 1'b0;
        else if (clr_en)
            wake_en <= 1'b0;
        else if (set_en)
            wake_en <= 1'b1;
    end

    assign trig = wake_en && suspended && (|csc);

    always_ff @(posedge clk) begin
        if (rst) resume_pulse <= 1'b0;
        else     resume_pulse <= trig;
    end

    // R4: clear command always disarms
    a_r4_clr_priority: assert property (@(posedge clk) disable iff (rst)
        clr_en |=> !wake_en);

    // R10: no resume without an armed enable during suspend
    a_r10_needs_armed: assert property (@(posedge clk) disable iff (rst)
        (!wake_en || !suspended) |=> !resume_pulse);

    // R10: qualified event yields the pulse
    a_r10_pulse: assert property (@(posedge clk) disable iff (rst)
        (wake_en && suspended && (csc != '0)) |=> resume_pulse);

endmodule

// File: rtl/rh_status_ctl.sv
module rh_status_ctl
    import rh_status_pkg::*;
#(
    parameter int          N_PORTS    = 4,
    parameter int          ADDR_W     = 8,
    parameter logic [7:0]  REG_OFFSET = 8'h50
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_wr,
    input  logic [REG_W-1:0]   bus_wdata,
    output logic [REG_W-1:0]   bus_rdata,
    input  logic               per_port_mode,
    input  logic               per_port_ovc,
    input  logic [N_PORTS-1:0] port_power_mask,
    output logic [N_PORTS-1:0] port_power,
    input  logic               ovc_in,
    input  logic [N_PORTS-1:0] port_csc,
    input  logic               suspended,
    output logic               resume_pulse
);
    localparam logic [ADDR_W-1:0] HIT_ADDR = ADDR_W'(REG_OFFSET);

    logic     hit;
    rh_cmd_t  cmd;
    rh_view_t view;
    logic     unused_wdata_bits;

    assign hit = (bus_addr == HIT_ADDR);
    assign cmd = decode_cmd(bus_wr && hit, bus_wdata);
    assign unused_wdata_bits = ^bus_wdata;

    rh_power_switch #(.N_PORTS(N_PORTS)) u_pwr (
        .clk           (clk),
        .rst           (rst),
        .cmd_set       (cmd.pwr_set),
        .cmd_clr       (cmd.pwr_clr),
        .per_port_mode (per_port_mode),
        .mask          (port_power_mask),
        .power         (port_power)
    );

    rh_ovc_track u_ovc (
        .clk          (clk),
        .rst          (rst),
        .ovc_async    (ovc_in),
        .per_port_ovc (per_port_ovc),
        .chg_clr      (cmd.chg_clr),
        .lvl          (view.ovc_lvl),
        .chg          (view.ovc_chg)
    );

    rh_wake_ctl #(.N_PORTS(N_PORTS)) u_wake (
        .clk          (clk),
        .rst          (rst),
        .set_en       (cmd.wake_set),
        .clr_en       (cmd.wake_clr),
        .suspended    (suspended),
        .csc          (port_csc),
        .wake_en      (view.wake_en),
        .resume_pulse (resume_pulse)
    );

    assign bus_rdata = hit ? pack_view(view) : '0;

    // R1: command-only and reserved positions never read back as 1
    a_r1_write_only_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rdata[B_PWR_CLR] == 1'b0) && (bus_rdata[B_PWR_SET] == 1'b0) &&
        (bus_rdata[B_WAKE_CLR] == 1'b0) && (bus_rdata[30:18] == '0) && (bus_rdata[14:2] == '0));

    // R8: level bit is quiet in per-port overcurrent mode
    a_r8_ovc_masked: assert property (@(posedge clk) disable iff (rst)
        (hit && per_port_ovc) |-> !bus_rdata[B_OVC_LVL]);

endmodule

// File: tb/rh_status_ctl_test.sv
module rh_status_ctl_test;
    localparam int  N = 4;
    localparam time CLK_PERIOD = 10ns;
    localparam logic [7:0] A = 8'h50;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   bus_addr = A;
    logic         bus_wr = 1'b0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         per_port_mode = 1'b0;
    logic         per_port_ovc = 1'b0;
    logic [N-1:0] port_power_mask = '0;
    logic [N-1:0] port_power;
    logic         ovc_in = 1'b0;
    logic [N-1:0] port_csc = '0;
    logic         suspended = 1'b0;
    logic         resume_pulse;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rh_status_ctl #(.N_PORTS(N)) uut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_port_mode(per_port_mode), .per_port_ovc(per_port_ovc),
        .port_power_mask(port_power_mask), .port_power(port_power),
        .ovc_in(ovc_in), .port_csc(port_csc), .suspended(suspended),
        .resume_pulse(resume_pulse)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d, input logic [7:0] a = A);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0; bus_addr = A;
    endtask

    task automatic rd(output logic [31:0] v, input logic [7:0] a = A);
        bus_addr = a;
        #1;
        v = bus_rdata;
        bus_addr = A;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(v);
        check("R2 status", v, 32'h0);
        check("R2 power", {28'b0, port_power}, 32'h0);
        check("R2 resume", {31'b0, resume_pulse}, 32'h0);
    endtask

    task automatic t_wake();
        logic [31:0] v;
        wr(32'h0000_8000); rd(v);
        check("R3 set wake", v, 32'h0000_8000);
        wr(32'h0000_0000); rd(v);
        check("R3 write 0 keeps wake", v, 32'h0000_8000);
        wr(32'h8000_0000); rd(v);
        check("R4 clear wake", v, 32'h0);
        wr(32'h8000_8000); rd(v);
        check("R4 clear beats set", v, 32'h0);
    endtask

    task automatic t_power_global();
        logic [31:0] v;
        per_port_mode = 1'b0;
        wr(32'h0001_0000); rd(v);
        check("R5 all on", {28'b0, port_power}, 32'hF);
        check("R5 bit16 reads 0", v, 32'h0);
        wr(32'h0000_0001); rd(v);
        check("R7 all off", {28'b0, port_power}, 32'h0);
        check("R7 bit0 reads 0", v, 32'h0);
        wr(32'h0001_0000);
        wr(32'h0001_0001);
        check("R7 clear beats set", {28'b0, port_power}, 32'h0);
    endtask

    task automatic t_power_perport();
        per_port_mode = 1'b1;
        port_power_mask = 4'b0101;
        wr(32'h0001_0000);
        check("R6 set unmasked only", {28'b0, port_power}, 32'hA);
        port_power_mask = 4'b0000;
        wr(32'h0001_0000);
        check("R6 set all unmasked", {28'b0, port_power}, 32'hF);
        port_power_mask = 4'b0101;
        wr(32'h0000_0001);
        check("R6 clear unmasked only", {28'b0, port_power}, 32'h5);
        port_power_mask = 4'b0011;
        wr(32'h0001_0001);
        check("R7 per-port clear beats set", {28'b0, port_power}, 32'h1);
        per_port_mode = 1'b0;
        port_power_mask = '0;
    endtask

    task automatic t_reserved_and_addr();
        logic [31:0] v;
        wr(32'h0001_8000);
        wr(32'h7FFC_7FFC); rd(v);
        check("R1 reserved write ignored", v, 32'h0000_8000);
        check("R1 reserved write power", {28'b0, port_power}, 32'hF);
        wr(32'h8000_0001, 8'h54); rd(v);
        check("R1 other addr write ignored", v, 32'h0000_8000);
        check("R1 other addr power kept", {28'b0, port_power}, 32'hF);
        rd(v, 8'h4C);
        check("R1 other addr reads 0", v, 32'h0);
        wr(32'h8000_0001);
    endtask

    task automatic t_ovc();
        logic [31:0] v;
        per_port_ovc = 1'b0;
        @(negedge clk); ovc_in = 1'b1;
        @(negedge clk); rd(v);
        check("R8 one edge no level", v, 32'h0);
        @(negedge clk); rd(v);
        check("R8 level after two edges", v, 32'h0000_0002);
        @(negedge clk); rd(v);
        check("R9 flag after three edges", v, 32'h0002_0002);
        repeat (3) @(negedge clk);
        rd(v);
        check("R9 flag holds", v, 32'h0002_0002);
        wr(32'h0002_0000); rd(v);
        check("R9 clear flag", v, 32'h0000_0002);
        wr(32'h0002_0000);
        @(negedge clk); ovc_in = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rd(v);
        check("R8 level low", v, 32'h0);
        bus_wdata = 32'h0002_0000; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
        rd(v);
        check("R9 set beats clear", v, 32'h0002_0000);
        wr(32'h0002_0000); rd(v);
        check("R9 clear after collision", v, 32'h0);
        per_port_ovc = 1'b1;
        @(negedge clk); ovc_in = 1'b1;
        repeat (4) @(negedge clk);
        rd(v);
        check("R8 per-port level 0", v, 32'h0);
        per_port_ovc = 1'b0;
        @(negedge clk); ovc_in = 1'b0;
        repeat (4) @(negedge clk);
        wr(32'h0002_0000);
    endtask

    task automatic t_resume();
        suspended = 1'b1;
        @(negedge clk); port_csc = 4'b0100;
        @(negedge clk); port_csc = '0;
        check("R10 no pulse when disarmed", {31'b0, resume_pulse}, 32'h0);
        wr(32'h0000_8000);
        suspended = 1'b0;
        @(negedge clk); port_csc = 4'b0001;
        @(negedge clk); port_csc = '0;
        check("R10 no pulse when awake", {31'b0, resume_pulse}, 32'h0);
        suspended = 1'b1;
        @(negedge clk); port_csc = 4'b1000;
        @(negedge clk); port_csc = '0;
        check("R10 pulse", {31'b0, resume_pulse}, 32'h1);
        @(negedge clk);
        check("R10 pulse one cycle", {31'b0, resume_pulse}, 32'h0);
        suspended = 1'b0;
        wr(32'h8000_0000);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst = 1'b0;
                t_reset();
                t_wake();
                t_power_global();
                t_power_perport();
                t_reserved_and_addr();
                t_ovc();
                t_resume();
            end
            begin
                repeat (5000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule